// File: doc/BRIEF.md
# Overridable Eight-Bit General-Purpose I/O Port

This block is an eight-bit bidirectional port. Software sets it up through two registers on a simple register bus. The data register holds the value that each pin drives when the pin is a general-purpose output. The direction register chooses, per bit, whether that pin is an input or an output. The block produces a pin-output vector and a pin-output-enable vector for the pads, and it takes the sensed pad levels back in on a pin-input vector.

The direction register does not always decide a pin's direction. Three sources can override it:
- When the serial peripheral interface is enabled, pins 2 to 4 follow that unit's drive requests.
- Pin 5 becomes the slave-select input, or an error-detect input when the unit is in master role.
- When the external bus mode is active, pins 6 and 7 carry the address and read/write strobes.

Pins 0 and 1 always stay plain general-purpose I/O.

Sensed levels pass through a two-flop synchronizer. The synchronized levels are used for register reads and are also forwarded to the peripheral. A mode-fault flag is raised for the peripheral when its error-detect input is pulled low.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the data register and the direction register both read 0x00. With no override active, every `pin_oe` bit is 0.
- R2: A write with `reg_addr`=0x08 loads the data latch, and a write with `reg_addr`=0x09 loads the direction register.
  - A read at 0x09 returns the direction register, and a read at any other address except 0x08 returns 0x00.
  - A read at 0x08 returns, per bit, `pin_out` if that bit's `pin_oe` is 1, and otherwise the synchronized pin level.
- R3: A general-purpose pin has `pin_oe` equal to its direction bit (1 = output, 0 = input) and `pin_out` equal to its latch bit.
  - This always holds for pins 0 and 1.
  - It holds for the other pins whenever no override applies.
  - A latch write made while the direction bit is 0 appears on the pin once the direction bit is set. `pin_out` only has meaning where `pin_oe` is 1.
- R4: While `bus_ext`=1, pins 6 and 7 are outputs whatever their direction bits hold. Pin 6 drives `bus_as` and pin 7 drives `bus_rw`.
- R5: With `spi_en`=1, pin 5 depends on the role and its direction bit:
  - In slave role (`spi_master`=0), pin 5 is an input and its direction bit has no effect.
  - In master role with direction bit 5 = 0, pin 5 is an input.
  - In master role with direction bit 5 = 1, pin 5 is an output driven from latch bit 5.
- R6: With `spi_en`=1, pin 2+k (k = 0..2) depends on `spi_drv_req[k]`:
  - If `spi_drv_req[k]`=0, the pin is an input regardless of its direction bit.
  - If `spi_drv_req[k]`=1, the pin drives `spi_drv_val[k]` only when its direction bit is 1; otherwise it is an input.
- R7: `spi_mode_fault` is 1 exactly when all of these hold: `spi_en`=1, `spi_master`=1, direction bit 5 = 0, and the synchronized level of pin 5 is 0.
- R8: A level applied to `pin_in` before a rising edge reaches the synchronized value after that edge and one more. `spi_pin_sync[k]` is the synchronized level of pin 2+k (k = 0..3).
- R9: A direction write takes effect on `pin_oe` at the rising edge that completes the write, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register bus address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pin_in | input | 8 | Sensed pad levels |
| pin_out | output | 8 | Value driven toward the pads |
| pin_oe | output | 8 | Per-pin output enable |
| spi_en | input | 1 | Serial peripheral enabled |
| spi_master | input | 1 | Serial peripheral in master role |
| spi_drv_req | input | 3 | Peripheral wants to drive pins 2..4 |
| spi_drv_val | input | 3 | Peripheral values for pins 2..4 |
| spi_pin_sync | output | 4 | Synchronized levels of pins 2..5 |
| spi_mode_fault | output | 1 | Error-detect input pulled low in master role |
| bus_ext | input | 1 | Expanded or test bus mode active |
| bus_as | input | 1 | Address strobe for pin 6 |
| bus_rw | input | 1 | Read/write strobe for pin 7 |

## Verification
Two things can land in the same clock cycle: a direction-register write, and a change of the peripheral enable, role or bus mode that takes the same pins away from the register. Random stimulus changes the mode inputs and issues register writes and reads independently on every cycle, so such collisions are frequent. The behavioural model then settles each pin by the fixed precedence: the bus mode first, then the peripheral, then the direction register. A second collision is a data-register read while pin 5 switches between driven and sensed. The model expects the read to follow whichever source owns the pin in that cycle.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int PORT_W = 8;
  localparam int SPI_LO = 2;
  localparam int SPI_N  = 3;
  localparam int SS_PIN = 5;
  localparam int BUS_LO = 6;
  localparam int SYNC_N = SS_PIN - SPI_LO + 1;

  typedef enum logic [1:0] {ROLE_GP, ROLE_SPI_IO, ROLE_SS, ROLE_BUS} pin_role_e;

  typedef struct packed {
    logic oe;
    logic val;
  } pin_drv_t;

  function automatic pin_role_e role_of(input int idx);
    if (idx >= BUS_LO) return ROLE_BUS;
    if (idx == SS_PIN) return ROLE_SS;
    if (idx >= SPI_LO && idx < SPI_LO + SPI_N) return ROLE_SPI_IO;
    return ROLE_GP;
  endfunction

  function automatic pin_drv_t gp_drive(input logic dir, input logic latch);
    pin_drv_t d;
    d.oe  = dir;
    d.val = latch;
    return d;
  endfunction

  function automatic pin_drv_t spi_io_drive(input logic en, input logic req,
                                            input logic dir, input logic latch,
                                            input logic sval);
    pin_drv_t d;
    if (!en) return gp_drive(dir, latch);
    d.oe  = req & dir;
    d.val = sval;
    return d;
  endfunction

  function automatic pin_drv_t ss_drive(input logic en, input logic master,
                                        input logic dir, input logic latch);
    pin_drv_t d;
    if (en && !master) begin
      d.oe  = 1'b0;
      d.val = latch;
      return d;
    end
    return gp_drive(dir, latch);
  endfunction

  function automatic pin_drv_t bus_drive(input logic ext, input logic dir,
                                         input logic latch, input logic strobe);
    pin_drv_t d;
    if (!ext) return gp_drive(dir, latch);
    d.oe  = 1'b1;
    d.val = strobe;
    return d;
  endfunction

  function automatic logic read_bit(input logic oe, input logic val, input logic sensed);
    return oe ? val : sensed;
  endfunction

  function automatic logic fault_of(input logic en, input logic master,
                                    input logic dir, input logic ss_level);
    return en & master & ~dir & ~ss_level;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int              ADDR_W   = 8,
  parameter int              W        = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] DIR_OFS  = 8'h09
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic              data_wr,
  output logic              dir_wr
);
  assign data_wr = we && (addr == DATA_OFS);
  assign dir_wr  = we && (addr == DIR_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (data_wr) latch_q <= wdata;
      if (dir_wr)  dir_q   <= wdata;
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_ovr_pkg::*;
(
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] latch_q,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic [SPI_N-1:0]  spi_req,
  input  logic [SPI_N-1:0]  spi_val,
  input  logic              bus_ext,
  input  logic              bus_as,
  input  logic              bus_rw,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_out
);
  generate
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      pin_drv_t drv;
      if (role_of(i) == ROLE_BUS) begin : g_bus
        assign drv = bus_drive(bus_ext, dir_q[i], latch_q[i],
                               (i == BUS_LO) ? bus_as : bus_rw);
      end else if (role_of(i) == ROLE_SS) begin : g_ss
        assign drv = ss_drive(spi_en, spi_master, dir_q[i], latch_q[i]);
      end else if (role_of(i) == ROLE_SPI_IO) begin : g_spi
        assign drv = spi_io_drive(spi_en, spi_req[i-SPI_LO], dir_q[i],
                                  latch_q[i], spi_val[i-SPI_LO]);
      end else begin : g_gp
        assign drv = gp_drive(dir_q[i], latch_q[i]);
      end
      assign pin_oe[i]  = drv.oe;
      assign pin_out[i] = drv.val;
    end
  endgenerate
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_ovr_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS    = 8'h08,
  parameter logic [ADDR_W-1:0] DIR_OFS     = 8'h09,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [7:0]        pin_in,
  output logic [7:0]        pin_out,
  output logic [7:0]        pin_oe,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic [2:0]        spi_drv_req,
  input  logic [2:0]        spi_drv_val,
  output logic [3:0]        spi_pin_sync,
  output logic              spi_mode_fault,
  input  logic              bus_ext,
  input  logic              bus_as,
  input  logic              bus_rw
);
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] sync_q;
  logic [PORT_W-1:0] rd_pins;
  logic              data_wr;
  logic              dir_wr;

  gpio_regs #(
    .ADDR_W(ADDR_W), .W(PORT_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .data_wr(data_wr), .dir_wr(dir_wr)
  );

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  gpio_pin_mux u_mux (
    .dir_q(dir_q), .latch_q(latch_q), .spi_en(spi_en), .spi_master(spi_master),
    .spi_req(spi_drv_req), .spi_val(spi_drv_val), .bus_ext(bus_ext),
    .bus_as(bus_as), .bus_rw(bus_rw), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  always_comb begin
    for (int i = 0; i < PORT_W; i++)
      rd_pins[i] = read_bit(pin_oe[i], pin_out[i], sync_q[i]);
  end

  always_comb begin
    if (reg_addr == DATA_OFS)     reg_rdata = rd_pins;
    else if (reg_addr == DIR_OFS) reg_rdata = dir_q;
    else                          reg_rdata = '0;
  end

  assign spi_pin_sync   = sync_q[SS_PIN:SPI_LO];
  assign spi_mode_fault = fault_of(spi_en, spi_master, dir_q[SS_PIN], sync_q[SS_PIN]);
endmodule

// File: rtl/gpio_ovr_chk.sv
module gpio_ovr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] pin_in,
  input logic [7:0] pin_oe,
  input logic [7:0] pin_out,
  input logic       spi_en,
  input logic       spi_master,
  input logic [2:0] spi_drv_req,
  input logic [3:0] spi_pin_sync,
  input logic       spi_mode_fault,
  input logic       bus_ext,
  input logic       bus_as,
  input logic       bus_rw,
  input logic       dir_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] dir_q
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_bus_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ext |-> (pin_oe[7:6] == 2'b11 && pin_out[7:6] == {bus_rw, bus_as}));

  assert_slave_ss_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_master) |-> !pin_oe[5]);

  assert_spi_inputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en |-> ((pin_oe[4:2] & ~spi_drv_req) == 3'b000));

  assert_fault_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode_fault |-> (spi_en && spi_master && !pin_oe[5] && !spi_pin_sync[3]));

  assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (spi_pin_sync == $past(pin_in[5:2], 2)));

  assert_dir_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (dir_q == $past(reg_wdata)));
endmodule

bind gpio_port_ovr gpio_ovr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
  .spi_en(spi_en), .spi_master(spi_master), .spi_drv_req(spi_drv_req),
  .spi_pin_sync(spi_pin_sync), .spi_mode_fault(spi_mode_fault),
  .bus_ext(bus_ext), .bus_as(bus_as), .bus_rw(bus_rw),
  .dir_wr(dir_wr), .reg_wdata(reg_wdata), .dir_q(dir_q)
);

// File: tb/sim_gpio_port_ovr.sv
module sim_gpio_port_ovr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [7:0] pin_in;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic       spi_en, spi_master;
  logic [2:0] spi_drv_req, spi_drv_val;
  logic [3:0] spi_pin_sync;
  logic       spi_mode_fault;
  logic       bus_ext, bus_as, bus_rw;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  gpio_port_ovr u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .spi_en(spi_en), .spi_master(spi_master),
    .spi_drv_req(spi_drv_req), .spi_drv_val(spi_drv_val),
    .spi_pin_sync(spi_pin_sync), .spi_mode_fault(spi_mode_fault),
    .bus_ext(bus_ext), .bus_as(bus_as), .bus_rw(bus_rw)
  );

  // Behavioural reference state
  logic [7:0] m_latch, m_dir, m_s1, m_s2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch <= 8'h00; m_dir <= 8'h00; m_s1 <= 8'h00; m_s2 <= 8'h00;
    end else begin
      if (reg_we && reg_addr == 8'h08) m_latch <= reg_wdata;
      if (reg_we && reg_addr == 8'h09) m_dir   <= reg_wdata;
      m_s1 <= pin_in;
      m_s2 <= m_s1;
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] eo, ev, erd, ord;
    for (int i = 0; i < 8; i++) begin
      logic o, v;
      o = m_dir[i];
      v = m_latch[i];
      if (i >= 6 && bus_ext) begin
        o = 1'b1;
        v = (i == 6) ? bus_as : bus_rw;
      end else if (i == 5 && spi_en) begin
        if (!spi_master) o = 1'b0;
      end else if (i >= 2 && i <= 4 && spi_en) begin
        o = spi_drv_req[i-2] & m_dir[i];
        v = spi_drv_val[i-2];
      end
      eo[i] = o;
      ev[i] = v;
      erd[i] = o ? v : m_s2[i];
    end
    chk("R3 gp pins", {12'd0, pin_oe[1:0], pin_out[1:0] & pin_oe[1:0]},
        {12'd0, eo[1:0], ev[1:0] & eo[1:0]});
    chk("R6 spi pins", {10'd0, pin_oe[4:2], pin_out[4:2] & pin_oe[4:2]},
        {10'd0, eo[4:2], ev[4:2] & eo[4:2]});
    chk("R5 select pin", {14'd0, pin_oe[5], pin_out[5] & pin_oe[5]},
        {14'd0, eo[5], ev[5] & eo[5]});
    chk("R4 strobe pins", {12'd0, pin_oe[7:6], pin_out[7:6] & pin_oe[7:6]},
        {12'd0, eo[7:6], ev[7:6] & eo[7:6]});
    if (reg_addr == 8'h08)      ord = erd;
    else if (reg_addr == 8'h09) ord = m_dir;
    else                        ord = 8'h00;
    chk("R2 read data", {8'd0, reg_rdata}, {8'd0, ord});
    chk("R7 mode fault", {15'd0, spi_mode_fault},
        {15'd0, spi_en & spi_master & ~m_dir[5] & ~m_s2[5]});
    chk("R8 synced pins", {12'd0, spi_pin_sync}, {12'd0, m_s2[5:2]});
  endtask

  task automatic set_idle();
    reg_addr = 8'h00; reg_we = 1'b0; reg_wdata = 8'h00; pin_in = 8'h00;
    spi_en = 1'b0; spi_master = 1'b0; spi_drv_req = 3'b000; spi_drv_val = 3'b000;
    bus_ext = 1'b0; bus_as = 1'b0; bus_rw = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    set_idle();
    reg_addr = 8'h09;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R1 dir after reset", {8'd0, reg_rdata}, 16'd0);
      chk("R1 oe after reset", {8'd0, pin_oe}, 16'd0);
    end
    rst_n = 1'b1;
    reg_addr = 8'h08;
    @(negedge clk);
    chk("R1 data after reset", {8'd0, reg_rdata}, 16'd0);

    // Latch written while pins are inputs, then direction opened
    reg_we = 1'b1; reg_addr = 8'h08; reg_wdata = 8'hA5;
    @(negedge clk);
    compare_all();
    chk("R3 latch hidden while input", {8'd0, pin_oe}, 16'd0);
    reg_addr = 8'h09; reg_wdata = 8'hFF;
    chk("R9 oe before write edge", {8'd0, pin_oe}, 16'd0);
    @(negedge clk);
    chk("R9 oe after write edge", {8'd0, pin_oe}, 16'h00FF);
    chk("R3 latch on pins", {8'd0, pin_out}, 16'h00A5);
    reg_we = 1'b0;

    // Slave role ignores direction bit 5; bus mode takes pins 6 and 7
    spi_en = 1'b1; spi_master = 1'b0; bus_ext = 1'b1; bus_as = 1'b1; bus_rw = 1'b0;
    @(negedge clk);
    compare_all();
    chk("R5 slave forces input", {15'd0, pin_oe[5]}, 16'd0);
    chk("R4 strobes driven", {14'd0, pin_out[7:6]}, 16'h0001);

    // Fault path: master, direction 5 cleared, pin 5 held low
    reg_we = 1'b1; reg_addr = 8'h09; reg_wdata = 8'h1F; spi_master = 1'b1; pin_in = 8'h00;
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    compare_all();
    chk("R7 fault raised", {15'd0, spi_mode_fault}, 16'd1);
    pin_in = 8'h20;
    @(negedge clk);
    chk("R8 not yet synced", {15'd0, spi_pin_sync[3]}, 16'd0);
    @(negedge clk);
    chk("R8 synced after two edges", {15'd0, spi_pin_sync[3]}, 16'd1);

    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r;
      @(negedge clk);
      compare_all();
      r = $urandom;
      reg_we    = r[0] & r[1];
      case (r[3:2])
        2'd0: reg_addr = 8'h08;
        2'd1: reg_addr = 8'h09;
        2'd2: reg_addr = {r[11:8], r[7:4]};
        default: reg_addr = 8'h08;
      endcase
      reg_wdata = r[19:12];
      if (r[20]) pin_in = r[28:21];
      if (r[29] & r[30]) begin
        logic [31:0] m;
        m = $urandom;
        spi_en = m[0] | m[1]; spi_master = m[2]; bus_ext = m[3] & m[4];
      end
      r = $urandom;
      spi_drv_req = r[2:0]; spi_drv_val = r[5:3]; bus_as = r[6]; bus_rw = r[7];
    end
    @(negedge clk);
    compare_all();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule